// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed master for the two-wire PHY management bus. Software sets up a frame format, a clock divider and the PHY and register addresses through four 32-bit registers on a simple synchronous register bus. Certain register writes launch frames as a side effect. The block then sends each 64-bit frame serially on MDC/MDIO and reports the outcome through status bits.

Both the short (Clause 22) and the extended (Clause 45) framing are supported. For a read, the master releases the data line through the turnaround. It collects sixteen bits from the PHY. If no PHY pulls the line low in the second turnaround bit, it raises a read-error flag. MDIO appears at the block edge as an output value, an output enable and an input. The pad and pull-up lie outside the block.

Register offsets on `regSel`: 0 = config/status, 1 = address selection, 2 = extended register address, 3 = data.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, config/status reads 0x00010208: busy bit 0 = 0, read-error bit 1 = 0, extended-mode bit 2 = 0, sample-edge bit 3 = 1, and divider bits [23:8] = 258. The address-selection register reads 0. `mdc` and `mdioOe` are low.
- R2: While a frame runs, one MDC period lasts 2 × (divider + 1) clock cycles, and MDC is low whenever no frame runs. With divider 0, no frame launches and MDC stays low, but the written register value is still stored.
- R3: Every frame is 64 bits, sent most significant first. The bits are: 32 ones, a 2-bit start code, a 2-bit opcode, the PHY address from selection bits [9:5], the device/register field from selection bits [4:0], 2 turnaround bits, and 16 data bits.
- R4: With bit 2 clear, a write to the data register sends start 01, opcode 01, turnaround 10 and the written value. A write to the selection register with bit 15 set sends start 01 and opcode 10.
- R5: With bit 2 set, a write to the extended address register sends start 00, opcode 00, turnaround 10 and that address. A data-register write sends start 00 and opcode 01. A read request sends start 00 and opcode 11.
- R6: With bit 2 clear, a write to the extended address register stores the value (readable back) and sends no frame.
- R7: During a read, the master drives MDIO through the device field and releases it from the first turnaround bit to the end. The 16 bits it receives appear in data register bits [15:0] once busy clears.
- R8: If the line is high at the second turnaround bit of a read, read-error (status bit 1) is set. A present PHY that drives 0 there leaves it clear. The flag is cleared when the next read launches.
- R9: Status bit 0 is high for the length of every frame. Data register bit 31 is high only during write and read frames, not address frames.
- R10: While status bit 0 is high, a write to any register is ignored and launches nothing.
- R11: Sample-edge bit 3 chooses where incoming bits are taken: 1 = at the MDC fall that ends the bit, 0 = at the MDC rise in the middle of the bit. In both settings, a PHY that holds each bit for the whole bit time reads back correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Value driven onto MDIO |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | Value seen on the MDIO line |

## Verification
The assertions assume that `mdioIn` is synchronous to `clk`. They also assume that `regSel` and `regWdata` are valid whenever `regWe` is high. The bench therefore changes every register-bus input only at falling clock edges. Its PHY responder changes the line only on MDC edges, and it leaves the line to a pull-up to model an absent PHY. Random frames keep the divider between 1 and 3 so that many frames fit in a run. The reset divider of 258 is checked only by reading it back.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam logic [5:0] SLOT_LAST     = 6'd63;
  localparam logic [5:0] SLOT_TA_FIRST = 6'd46;
  localparam logic [5:0] SLOT_TA_LAST  = 6'd47;
  localparam logic [5:0] SLOT_DATA     = 6'd48;

  localparam logic [1:0] SEL_CFG  = 2'd0;
  localparam logic [1:0] SEL_PICK = 2'd1;
  localparam logic [1:0] SEL_ADDR = 2'd2;
  localparam logic [1:0] SEL_DATA = 2'd3;

  typedef struct packed {
    logic        start;
    logic        isRead;
    logic [63:0] frame;
  } mdioCmd_t;

  function automatic logic [63:0] buildFrame(input logic [1:0] st, input logic [1:0] op,
                                             input logic [4:0] pa, input logic [4:0] da,
                                             input logic [1:0] ta, input logic [15:0] payload);
    return {32'hFFFF_FFFF, st, op, pa, da, ta, payload};
  endfunction
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int unsigned RESET_DIV = 258
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regSel,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             frameActive,
  input  logic             frameDone,
  input  logic [15:0]      rdData,
  input  logic             taBit,
  output mdioCmd_t         cmd,
  output logic [DIV_W-1:0] divVal,
  output logic             negSel,
  output logic             xferActive
);
  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(RESET_DIV);

  logic             encQ, negQ, readErrQ, xferQ, readPendQ;
  logic [DIV_W-1:0] divQ;
  logic [4:0]       portQ, devQ;
  logic [15:0]      addrQ, dataQ;
  logic             wrOk, divNz;
  logic [1:0]       stCode;
  logic             unusedBits;

  assign unusedBits = ^{regWdata[31:24], regWdata[14:10], regWdata[7:4], regWdata[1:0]};
  assign wrOk   = regWe && !frameActive;
  assign divNz  = (divQ != '0);
  assign stCode = encQ ? 2'b00 : 2'b01;

  always_comb begin
    cmd = '0;
    if (wrOk && divNz) begin
      unique case (regSel)
        SEL_ADDR: if (encQ) begin
          cmd.start = 1'b1;
          cmd.frame = buildFrame(2'b00, 2'b00, portQ, devQ, 2'b10, regWdata[15:0]);
        end
        SEL_DATA: begin
          cmd.start = 1'b1;
          cmd.frame = buildFrame(stCode, 2'b01, portQ, devQ, 2'b10, regWdata[15:0]);
        end
        SEL_PICK: if (regWdata[15]) begin
          cmd.start  = 1'b1;
          cmd.isRead = 1'b1;
          cmd.frame  = buildFrame(stCode, encQ ? 2'b11 : 2'b10, regWdata[9:5],
                                  regWdata[4:0], 2'b11, 16'hFFFF);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      encQ <= 1'b0; negQ <= 1'b1; divQ <= DIV_INIT;
      portQ <= '0; devQ <= '0; addrQ <= '0; dataQ <= '0;
      readErrQ <= 1'b0; xferQ <= 1'b0; readPendQ <= 1'b0;
    end else begin
      if (frameDone) begin
        xferQ <= 1'b0;
        if (readPendQ) begin
          dataQ     <= rdData;
          readErrQ  <= taBit;
          readPendQ <= 1'b0;
        end
      end
      if (wrOk) begin
        unique case (regSel)
          SEL_CFG: begin
            encQ <= regWdata[2];
            negQ <= regWdata[3];
            divQ <= regWdata[8 +: DIV_W];
          end
          SEL_PICK: begin
            devQ  <= regWdata[4:0];
            portQ <= regWdata[9:5];
          end
          SEL_ADDR: addrQ <= regWdata[15:0];
          SEL_DATA: dataQ <= regWdata[15:0];
          default: ;
        endcase
      end
      if (cmd.start) begin
        xferQ     <= (regSel != SEL_ADDR);
        readPendQ <= cmd.isRead;
        if (cmd.isRead) readErrQ <= 1'b0;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regSel)
      SEL_CFG: begin
        regRdata[0]          = frameActive;
        regRdata[1]          = readErrQ;
        regRdata[2]          = encQ;
        regRdata[3]          = negQ;
        regRdata[8 +: DIV_W] = divQ;
      end
      SEL_PICK: begin
        regRdata[4:0] = devQ;
        regRdata[9:5] = portQ;
      end
      SEL_ADDR: regRdata[15:0] = addrQ;
      default: begin
        regRdata[15:0] = dataQ;
        regRdata[31]   = xferQ;
      end
    endcase
  end

  assign divVal     = divQ;
  assign negSel     = negQ;
  assign xferActive = xferQ;
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdioCmd_t         cmd,
  input  logic [DIV_W-1:0] divVal,
  input  logic             negSel,
  input  logic             mdioIn,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  output logic             frameActive,
  output logic             frameDone,
  output logic [15:0]      rdData,
  output logic             taBit
);
  logic             active, mdcQ, mdoQ, oeQ, isReadQ, taQ;
  logic [DIV_W-1:0] divCnt;
  logic [5:0]       slotCnt, nextSlot;
  logic [63:0]      shiftQ;
  logic [15:0]      rdShift, rdNext;
  logic             divNz, tick, riseNow, fallNow, sampleNow;

  assign divNz     = (divVal != '0);
  assign tick      = active && divNz && (divCnt == divVal);
  assign riseNow   = tick && !mdcQ;
  assign fallNow   = tick && mdcQ;
  assign sampleNow = negSel ? fallNow : riseNow;
  assign nextSlot  = slotCnt + 6'd1;
  assign rdNext    = (sampleNow && isReadQ && slotCnt >= SLOT_DATA) ? {rdShift[14:0], mdioIn} : rdShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0; mdcQ <= 1'b0; divCnt <= '0; slotCnt <= '0;
      shiftQ <= '0; mdoQ <= 1'b1; oeQ <= 1'b0; isReadQ <= 1'b0;
      rdShift <= '0; taQ <= 1'b0;
    end else if (!active) begin
      if (cmd.start) begin
        active  <= 1'b1;
        shiftQ  <= {cmd.frame[62:0], 1'b0};
        mdoQ    <= cmd.frame[63];
        oeQ     <= 1'b1;
        slotCnt <= '0;
        divCnt  <= '0;
        mdcQ    <= 1'b0;
        isReadQ <= cmd.isRead;
        rdShift <= '0;
        taQ     <= 1'b0;
      end
    end else if (divNz) begin
      if (tick) begin
        divCnt <= '0;
        mdcQ   <= ~mdcQ;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
      rdShift <= rdNext;
      if (sampleNow && isReadQ && slotCnt == SLOT_TA_LAST) taQ <= mdioIn;
      if (fallNow) begin
        if (slotCnt == SLOT_LAST) begin
          active <= 1'b0;
          oeQ    <= 1'b0;
          mdoQ   <= 1'b1;
        end else begin
          slotCnt <= nextSlot;
          mdoQ    <= shiftQ[63];
          shiftQ  <= {shiftQ[62:0], 1'b0};
          oeQ     <= !(isReadQ && nextSlot >= SLOT_TA_FIRST);
        end
      end
    end
  end

  assign mdc         = mdcQ;
  assign mdioOut     = mdoQ;
  assign mdioOe      = oeQ;
  assign frameActive = active;
  assign frameDone   = fallNow && (slotCnt == SLOT_LAST);
  assign rdData      = rdNext;
  assign taBit       = taQ;
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int unsigned RESET_DIV = 258
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regSel,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdioCmd_t         cmd;
  logic [DIV_W-1:0] divVal;
  logic             negSel, xferActive, frameActive, frameDone, taBit;
  logic [15:0]      rdData;

  mdio_ctrl #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .frameActive(frameActive), .frameDone(frameDone),
    .rdData(rdData), .taBit(taBit), .cmd(cmd), .divVal(divVal), .negSel(negSel),
    .xferActive(xferActive)
  );

  mdio_dp #(.DIV_W(DIV_W)) dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .divVal(divVal), .negSel(negSel),
    .mdioIn(mdioIn), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .frameActive(frameActive), .frameDone(frameDone), .rdData(rdData), .taBit(taBit)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             mdc,
  input logic             mdioOe,
  input logic             frameActive,
  input logic             xferActive,
  input logic             launch,
  input logic [DIV_W-1:0] divVal
);
  assert_mdc_idle_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    !frameActive |-> !mdc);

  assert_mdc_frozen_div0_R2: assert property (@(posedge clk) disable iff (!rstN)
    (divVal == '0) |=> $stable(mdc));

  assert_launch_needs_div_R2: assert property (@(posedge clk) disable iff (!rstN)
    launch |-> (divVal != '0));

  assert_no_launch_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    frameActive |-> !launch);

  assert_xfer_within_frame_R9: assert property (@(posedge clk) disable iff (!rstN)
    xferActive |-> frameActive);

  assert_oe_only_in_frame_R7: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> frameActive);
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.DIV_W(DIV_W)) chk (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioOe(mdioOe), .frameActive(frameActive),
  .xferActive(xferActive), .launch(cmd.start), .divVal(divVal)
);

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        mdc, mdioOut, mdioOe, mdioLine;

  logic        phyPresent = 1'b1, phyOe = 1'b0, phyBit = 1'b1, phyRead = 1'b0;
  logic [15:0] phyRetVal = '0;
  logic [63:0] capBits = '0;
  int          riseCnt = 0, fallCnt = 0;
  time         lastRise = 0, lastPeriod = 0;
  int          checks = 0, errors = 0, cycles = 0;

  assign mdioLine = mdioOe ? mdioOut : (phyOe ? phyBit : 1'b1);

  mdio_mgmt_master uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioLine)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge mdc) begin
    capBits = {capBits[62:0], mdioLine};
    if (riseCnt > 0) lastPeriod = $time - lastRise;
    lastRise = $time;
    riseCnt++;
    if (riseCnt == 35) phyRead = mdioLine;
  end

  always @(negedge mdc) begin
    fallCnt++;
    phyOe = 1'b0;
    if (phyRead && phyPresent) begin
      if (fallCnt == 47) begin phyOe = 1'b1; phyBit = 1'b0; end
      else if (fallCnt >= 48 && fallCnt <= 63) begin
        phyOe = 1'b1; phyBit = phyRetVal[63 - fallCnt];
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expFrame(input logic [1:0] st, input logic [1:0] op,
      input logic [4:0] pa, input logic [4:0] da, input logic [1:0] ta, input logic [15:0] d);
    return {32'hFFFF_FFFF, st, op, pa, da, ta, d};
  endfunction

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    regSel = sel; regWdata = val; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [31:0] val);
    @(negedge clk);
    regSel = sel;
    #1 val = regRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    v = 32'h1;
    while (v[0]) regRead(2'd0, v);
  endtask

  task automatic resetPhy();
    riseCnt = 0; fallCnt = 0; phyRead = 1'b0; phyOe = 1'b0; capBits = '0;
  endtask

  function automatic logic [31:0] cfgWord(input logic enc, input logic neg, input logic [15:0] dv);
    return {8'h0, dv, 4'h0, neg, enc, 2'b00};
  endfunction

  // kind: 0 = address frame, 1 = write frame, 2 = read frame
  task automatic doFrame(input int kind, input logic enc, input logic [4:0] pa,
                         input logic [4:0] da, input logic [15:0] d, input logic neg,
                         input logic [15:0] dv, input logic present);
    logic [31:0] v;
    logic [1:0] st;
    st = enc ? 2'b00 : 2'b01;
    regWrite(2'd0, cfgWord(enc, neg, dv));
    resetPhy();
    phyPresent = present; phyRetVal = d;
    if (kind == 2) regWrite(2'd1, {16'h0, 1'b1, 5'h0, pa, da});
    else begin
      regWrite(2'd1, {22'h0, pa, da});
      regWrite(kind == 0 ? 2'd2 : 2'd3, {16'h0, d});
    end
    regRead(2'd0, v);
    check("R9 busy during frame", v[0], 1'b1);
    regRead(2'd3, v);
    check("R9 transfer busy only for write/read", v[31], kind != 0);
    waitIdle();
    check("R3 one frame of 64 MDC cycles", riseCnt, 64);
    check("R2 MDC period", lastPeriod, 2 * (dv + 1) * CLK_PERIOD);
    check("R2 MDC low after frame", mdc, 1'b0);
    if (kind == 0)
      check("R5 address frame", capBits, expFrame(2'b00, 2'b00, pa, da, 2'b10, d));
    else if (kind == 1)
      check(enc ? "R5 write frame" : "R4 write frame", capBits, expFrame(st, 2'b01, pa, da, 2'b10, d));
    else begin
      check(enc ? "R5 read header" : "R4 read header", capBits[63:18],
            expFrame(st, enc ? 2'b11 : 2'b10, pa, da, 2'b00, 16'h0) >> 18);
      regRead(2'd3, v);
      check(neg ? "R7 R11 read data fall-edge sampling" : "R7 R11 read data rise-edge sampling",
            v[15:0], present ? d : 16'hFFFF);
      regRead(2'd0, v);
      check("R8 read error flag", v[1], !present);
      check("R7 line released after read", mdioOe, 1'b0);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    regRead(2'd0, v);
    check("R1 reset config/status", v, 32'h0001_0208);
    regRead(2'd1, v);
    check("R1 reset selection register", v, 32'h0);
    check("R1 reset mdc", mdc, 1'b0);
    check("R1 reset mdioOe", mdioOe, 1'b0);

    // R6: short-format address write stores only
    regWrite(2'd0, cfgWord(1'b0, 1'b1, 16'd2));
    resetPhy();
    regWrite(2'd2, 32'h0000_BEEF);
    regRead(2'd0, v);
    check("R6 no frame from address write", v[0], 1'b0);
    repeat (40) @(negedge clk);
    check("R6 no MDC activity", riseCnt, 0);
    regRead(2'd2, v);
    check("R6 address stored", v[15:0], 16'hBEEF);

    // R2: divider zero
    regWrite(2'd0, cfgWord(1'b0, 1'b1, 16'd0));
    resetPhy();
    regWrite(2'd3, 32'h0000_1234);
    regRead(2'd0, v);
    check("R2 divider zero launches nothing", v[0], 1'b0);
    repeat (40) @(negedge clk);
    check("R2 divider zero keeps MDC still", riseCnt, 0);
    regRead(2'd3, v);
    check("R2 divider zero still stores data", v[15:0], 16'h1234);

    // Directed frames in both formats and both sample edges
    doFrame(1, 1'b0, 5'h1F, 5'h00, 16'hA55A, 1'b1, 16'd1, 1'b1);
    doFrame(2, 1'b0, 5'h03, 5'h11, 16'h8001, 1'b1, 16'd1, 1'b1);
    doFrame(2, 1'b0, 5'h03, 5'h11, 16'h7FFE, 1'b0, 16'd2, 1'b1);
    doFrame(0, 1'b1, 5'h0A, 5'h1E, 16'hFFFF, 1'b0, 16'd3, 1'b1);
    doFrame(2, 1'b1, 5'h00, 5'h1F, 16'h0000, 1'b1, 16'd1, 1'b1);
    doFrame(2, 1'b1, 5'h15, 5'h05, 16'h1357, 1'b0, 16'd1, 1'b0);
    doFrame(2, 1'b0, 5'h15, 5'h05, 16'h2468, 1'b1, 16'd1, 1'b1);

    // R10: writes while busy are ignored
    regWrite(2'd0, cfgWord(1'b0, 1'b1, 16'd1));
    resetPhy();
    regWrite(2'd1, 32'h0000_0045);
    regWrite(2'd3, 32'h0000_C0DE);
    regWrite(2'd3, 32'h0000_0BAD);
    regWrite(2'd1, 32'h0000_83FF);
    regWrite(2'd0, cfgWord(1'b1, 1'b0, 16'd7));
    waitIdle();
    repeat (20) @(negedge clk);
    check("R10 only one frame sent", riseCnt, 64);
    check("R10 frame carries first value", capBits, expFrame(2'b01, 2'b01, 5'h02, 5'h05, 2'b10, 16'hC0DE));
    regRead(2'd3, v);
    check("R10 data write ignored", v[15:0], 16'hC0DE);
    regRead(2'd1, v);
    check("R10 selection write ignored", v, 32'h0000_0045);
    regRead(2'd0, v);
    check("R10 config write ignored", v, cfgWord(1'b0, 1'b1, 16'd1));

    // Constrained random frames
    for (int i = 0; i < 30; i++) begin
      logic enc, neg, present;
      int kind;
      enc = 1'($urandom % 2);
      kind = enc ? int'($urandom % 3) : int'(1 + $urandom % 2);
      neg = 1'($urandom % 2);
      present = (($urandom % 4) != 0);
      doFrame(kind, enc, 5'($urandom), 5'($urandom), 16'($urandom), neg,
              16'(1 + $urandom % 3), present);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule